// File: doc/BRIEF.md
# Byte-Packed Block Data FIFO Engine

This block sits between a register-mapped bus port and a byte-wide card data port and moves one block transfer of data between them. It holds two circular byte stores of 32 entries each, one for received bytes and one for bytes to transmit. Bus accesses are 1, 2 or 4 bytes wide. A 4-byte read takes up to four bytes out of the receive store in one access, and a 4-byte write puts up to four bytes into the transmit store in one access.

A transfer starts with a one-cycle start pulse. The pulse samples the direction, a 12-bit block length and a 16-bit block count. The engine then counts the byte total down as bytes cross the card port, at most one byte per cycle. It raises a request when the receive store needs emptying or the transmit store needs filling. It raises a completion flag when the total runs out, and for writes a second flag reporting that programming is complete. A flush input pushes out a transmit store that is only partly filled.

Top module: `dfifo_engine`

## Requirements
- R1: After reset both stores are empty (`rx_level_o` and `tx_level_o` read 0), and all request and done flags and both card strobes are low. A store's level never exceeds 32.
- R2: In read direction (`dir_wr_i` = 0 at start), the engine takes one byte from `card_rdata_i` in each cycle where `card_rd_o` is high. It does so while bytes of the total remain and the receive store holds fewer than 32. `card_rd_o` is low while the store is full.
- R3: In write direction (`dir_wr_i` = 1 at start), the engine sends the oldest transmit byte on `card_wdata_o` with `card_wr_o` high, one byte per cycle. It does so only while bytes of the total remain, the store is non-empty, and one of three conditions holds: the store is full, the store holds at least the remaining count, or a flush is pending. Bytes leave in the order they were written.
- R4: A bus read with `rx_size_i` 0, 1 or 2 (3 acts as 2) removes up to 1, 2 or 4 bytes. The first byte removed goes into the most significant of the N lanes, and the following bytes fill lower lanes. Lanes for bytes the store did not hold read 0, as do all lanes above N.
- R5: A bus write with `tx_size_i` coded as in R4 stores the N lanes in order, most significant lane first. Lanes that find the store full are discarded.
- R6: `rx_req_o` is set when the receive store is non-empty in read direction and is either full or the byte total has reached zero. A bus read clears it for the following cycle, after which it is evaluated again.
- R7: `tx_req_o` is set when a write transfer has bytes remaining and the transmit store is empty. A bus write clears it for the following cycle.
- R8: When the remaining total reaches zero, `data_done_o` rises on the next cycle. For a write transfer `prog_done_o` rises with it. Both stay high until the next start, and no card byte moves while `data_done_o` is high.
- R9: A pulse on `flush_i` makes a partly filled transmit store drain to empty even though it holds fewer bytes than remain.
- R10: The byte total is `blk_len_i` × `blk_cnt_i`. A zero total raises the done flags within two cycles of the start.
- R11: No more than one byte crosses the card port per cycle, and `card_rd_o` and `card_wr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads the total and direction |
| dir_wr_i | input | 1 | Direction sampled at start: 1 = write to card |
| blk_len_i | input | 12 | Bytes per block |
| blk_cnt_i | input | 16 | Number of blocks |
| flush_i | input | 1 | Force a partly filled transmit store out |
| rx_rd_i | input | 1 | Bus read of the receive store |
| rx_size_i | input | 2 | Read access size code |
| rx_rdata_o | output | 32 | Packed read data, valid while `rx_rd_i` is high |
| tx_wr_i | input | 1 | Bus write of the transmit store |
| tx_size_i | input | 2 | Write access size code |
| tx_wdata_i | input | 32 | Bus write data |
| card_rd_o | output | 1 | Byte taken from the card this cycle |
| card_rdata_i | input | 8 | Byte offered by the card |
| card_wr_o | output | 1 | Byte sent to the card this cycle |
| card_wdata_o | output | 8 | Byte sent to the card |
| rx_level_o | output | 6 | Receive store fill level |
| tx_level_o | output | 6 | Transmit store fill level |
| rx_req_o | output | 1 | Receive service request |
| tx_req_o | output | 1 | Transmit service request |
| data_done_o | output | 1 | Byte total exhausted |
| prog_done_o | output | 1 | Write transfer finished |

## Verification
The assertions assume a byte is available on `card_rdata_i` in every cycle where `card_rd_o` is high. They also assume `start_i` is a single-cycle pulse and that software does not change direction during a transfer. The stimulus follows these rules: a card model always presents its next byte, each start is issued as one pulse, and direction changes only with a new start. Bus writes to the transmit store are also issued while no transfer is active, so that the overflow discard can be seen without bytes leaving at the same time.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // bytes moved by one bus access, clamped to the bus width
  function automatic int lane_count(logic [1:0] sz, int lanes);
    int n;
    n = 1 << sz;
    return (n > lanes) ? lanes : n;
  endfunction
endpackage

// File: rtl/dfifo_store.sv
module dfifo_store #(
  parameter int DEPTH  = 32,
  parameter int PUSH_W = 4,
  parameter int POP_W  = 4,
  localparam int AW  = $clog2(DEPTH),
  localparam int LW  = AW + 1,
  localparam int PCW = $clog2(PUSH_W + 1),
  localparam int OCW = $clog2(POP_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PCW-1:0]    push_cnt_i,
  input  logic [PUSH_W*8-1:0] push_data_i,
  input  logic [OCW-1:0]    pop_cnt_i,
  output logic [POP_W*8-1:0] pop_data_o,
  output logic [LW-1:0]     level_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] head_q;
  logic [LW-1:0] level_q;
  logic [LW-1:0] room, push_ok, pop_ok;
  logic [AW-1:0] tail;

  always_comb begin
    room    = LW'(DEPTH) - level_q;
    push_ok = (LW'(push_cnt_i) > room) ? room : LW'(push_cnt_i);
    pop_ok  = (LW'(pop_cnt_i) > level_q) ? level_q : LW'(pop_cnt_i);
    tail    = head_q + AW'(level_q);
  end

  always_comb begin
    for (int i = 0; i < POP_W; i++) begin
      pop_data_o[i*8 +: 8] = (LW'(i) < pop_ok) ? mem_q[head_q + AW'(i)] : 8'h00;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PUSH_W; i++) begin
      if (LW'(i) < push_ok) mem_q[tail + AW'(i)] <= push_data_i[i*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      level_q <= '0;
    end else begin
      head_q  <= head_q + AW'(pop_ok);
      level_q <= level_q + push_ok - pop_ok;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/dfifo_pack.sv
module dfifo_pack import dfifo_pkg::*; #(
  parameter int LANES = 4,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic [1:0]         size_i,
  input  logic [LANES*8-1:0] bytes_i,
  output logic [NW-1:0]      nbytes_o,
  output logic [LANES*8-1:0] bus_o
);
  int n;
  always_comb begin
    n        = lane_count(size_i, LANES);
    nbytes_o = NW'(n);
    bus_o    = '0;
    // first byte out of the store lands in the top lane of the access
    for (int i = 0; i < LANES; i++) begin
      if (i < n) bus_o[(n-1-i)*8 +: 8] = bytes_i[i*8 +: 8];
    end
  end
endmodule

// File: rtl/dfifo_unpack.sv
module dfifo_unpack import dfifo_pkg::*; #(
  parameter int LANES = 4,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic [1:0]         size_i,
  input  logic [LANES*8-1:0] bus_i,
  output logic [NW-1:0]      nbytes_o,
  output logic [LANES*8-1:0] bytes_o
);
  int n;
  always_comb begin
    n        = lane_count(size_i, LANES);
    nbytes_o = NW'(n);
    bytes_o  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < n) bytes_o[i*8 +: 8] = bus_i[(n-1-i)*8 +: 8];
    end
  end
endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int LW = $clog2(DEPTH) + 1,
  localparam int CW = LEN_W + CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             flush_i,
  input  logic             rx_rd_i,
  input  logic             tx_wr_i,
  input  logic [LW-1:0]    rx_level_i,
  input  logic [LW-1:0]    tx_level_i,
  output logic             pull_o,
  output logic             drain_o,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             data_done_o,
  output logic             prog_done_o
);
  logic [CW-1:0] remain_q;
  logic active_q, wr_q, flush_q;
  logic rx_req_q, tx_req_q, ddone_q, pdone_q;
  logic has_bytes, tx_ready, rx_set, tx_set;

  always_comb begin
    has_bytes = active_q && (remain_q != '0);
    // hold transmit bytes back until a full store, the tail of the transfer, or a flush
    tx_ready  = (tx_level_i == LW'(DEPTH)) || (CW'(tx_level_i) >= remain_q) || flush_q;
    pull_o    = has_bytes && !wr_q && (rx_level_i < LW'(DEPTH));
    drain_o   = has_bytes && wr_q && (tx_level_i != '0) && tx_ready;
    rx_set    = !wr_q && (rx_level_i != '0) &&
                ((rx_level_i == LW'(DEPTH)) || (remain_q == '0));
    tx_set    = has_bytes && wr_q && (tx_level_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      flush_q  <= 1'b0;
      ddone_q  <= 1'b0;
      pdone_q  <= 1'b0;
    end else if (start_i) begin
      remain_q <= CW'(blk_len_i) * CW'(blk_cnt_i);
      active_q <= 1'b1;
      wr_q     <= dir_wr_i;
      flush_q  <= 1'b0;
      ddone_q  <= 1'b0;
      pdone_q  <= 1'b0;
    end else begin
      if (pull_o || drain_o) remain_q <= remain_q - 1'b1;
      if (active_q && remain_q == '0) begin
        active_q <= 1'b0;
        ddone_q  <= 1'b1;
        pdone_q  <= wr_q;
      end
      flush_q <= (flush_q || flush_i) && (tx_level_i != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_req_q <= 1'b0;
      tx_req_q <= 1'b0;
    end else begin
      rx_req_q <= rx_rd_i ? 1'b0 : (rx_req_q || rx_set);
      tx_req_q <= tx_wr_i ? 1'b0 : (tx_req_q || tx_set);
    end
  end

  assign rx_req_o    = rx_req_q;
  assign tx_req_o    = tx_req_q;
  assign data_done_o = ddone_q;
  assign prog_done_o = pdone_q;
endmodule

// File: rtl/dfifo_engine.sv
module dfifo_engine #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int LW = $clog2(DEPTH) + 1,
  localparam int BW = LANES * 8,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             flush_i,
  input  logic             rx_rd_i,
  input  logic [1:0]       rx_size_i,
  output logic [BW-1:0]    rx_rdata_o,
  input  logic             tx_wr_i,
  input  logic [1:0]       tx_size_i,
  input  logic [BW-1:0]    tx_wdata_i,
  output logic             card_rd_o,
  input  logic [7:0]       card_rdata_i,
  output logic             card_wr_o,
  output logic [7:0]       card_wdata_o,
  output logic [LW-1:0]    rx_level_o,
  output logic [LW-1:0]    tx_level_o,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             data_done_o,
  output logic             prog_done_o
);
  logic          pull, drain;
  logic [NW-1:0] rd_n, wr_n, rx_pop_cnt, tx_push_cnt;
  logic [BW-1:0] rx_pop_bytes, tx_push_bytes;

  assign rx_pop_cnt  = rx_rd_i ? rd_n : '0;
  assign tx_push_cnt = tx_wr_i ? wr_n : '0;

  dfifo_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .dir_wr_i, .blk_len_i, .blk_cnt_i, .flush_i,
    .rx_rd_i, .tx_wr_i,
    .rx_level_i (rx_level_o),
    .tx_level_i (tx_level_o),
    .pull_o     (pull),
    .drain_o    (drain),
    .rx_req_o, .tx_req_o, .data_done_o, .prog_done_o
  );

  dfifo_store #(.DEPTH(DEPTH), .PUSH_W(1), .POP_W(LANES)) i_rx_store (
    .clk_i, .rst_ni,
    .push_cnt_i  (pull),
    .push_data_i (card_rdata_i),
    .pop_cnt_i   (rx_pop_cnt),
    .pop_data_o  (rx_pop_bytes),
    .level_o     (rx_level_o)
  );

  dfifo_pack #(.LANES(LANES)) i_rx_pack (
    .size_i   (rx_size_i),
    .bytes_i  (rx_pop_bytes),
    .nbytes_o (rd_n),
    .bus_o    (rx_rdata_o)
  );

  dfifo_unpack #(.LANES(LANES)) i_tx_unpack (
    .size_i   (tx_size_i),
    .bus_i    (tx_wdata_i),
    .nbytes_o (wr_n),
    .bytes_o  (tx_push_bytes)
  );

  dfifo_store #(.DEPTH(DEPTH), .PUSH_W(LANES), .POP_W(1)) i_tx_store (
    .clk_i, .rst_ni,
    .push_cnt_i  (tx_push_cnt),
    .push_data_i (tx_push_bytes),
    .pop_cnt_i   (drain),
    .pop_data_o  (card_wdata_o),
    .level_o     (tx_level_o)
  );

  assign card_rd_o = pull;
  assign card_wr_o = drain;
endmodule

// File: rtl/dfifo_engine_chk.sv
module dfifo_engine_chk #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_rd_i,
  input logic          tx_wr_i,
  input logic          card_rd_o,
  input logic          card_wr_o,
  input logic [LW-1:0] rx_level_o,
  input logic [LW-1:0] tx_level_o,
  input logic          rx_req_o,
  input logic          tx_req_o,
  input logic          data_done_o,
  input logic          prog_done_o
);
  AST_RX_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_o <= LW'(DEPTH)); // R1
  AST_RX_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_rd_i && !card_rd_o) |=> $stable(rx_level_o)); // R1
  AST_PULL_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rd_o |-> (rx_level_o < LW'(DEPTH))); // R2
  AST_DRAIN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_wr_o |-> (tx_level_o != '0)); // R3
  AST_TX_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_wr_i && !card_wr_o) |=> $stable(tx_level_o)); // R5
  AST_RXREQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i |=> !rx_req_o); // R6
  AST_TXREQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !tx_req_o); // R7
  AST_PROG_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_done_o |-> data_done_o); // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_done_o |-> (!card_rd_o && !card_wr_o)); // R8
  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_rd_o && card_wr_o)); // R11
endmodule

bind dfifo_engine dfifo_engine_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i, .rst_ni, .rx_rd_i, .tx_wr_i, .card_rd_o, .card_wr_o,
  .rx_level_o, .tx_level_o, .rx_req_o, .tx_req_o, .data_done_o, .prog_done_o
);

// File: tb/test_dfifo_engine.sv
`timescale 1ns/1ps
module test_dfifo_engine;
  localparam int DEPTH = 32;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start_i = 0, dir_wr_i = 0, flush_i = 0;
  logic [11:0] blk_len_i = '0;
  logic [15:0] blk_cnt_i = '0;
  logic        rx_rd_i = 0, tx_wr_i = 0;
  logic [1:0]  rx_size_i = '0, tx_size_i = '0;
  logic [31:0] tx_wdata_i = '0, rx_rdata_o;
  logic        card_rd_o, card_wr_o;
  logic [7:0]  card_rdata_i, card_wdata_o;
  logic [LW-1:0] rx_level_o, tx_level_o;
  logic        rx_req_o, tx_req_o, data_done_o, prog_done_o;

  dfifo_engine i_dfifo_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .dir_wr_i, .blk_len_i, .blk_cnt_i,
    .flush_i, .rx_rd_i, .rx_size_i, .rx_rdata_o, .tx_wr_i, .tx_size_i,
    .tx_wdata_i, .card_rd_o, .card_rdata_i, .card_wr_o, .card_wdata_o,
    .rx_level_o, .tx_level_o, .rx_req_o, .tx_req_o, .data_done_o, .prog_done_o
  );

  int n_chk = 0, n_err = 0, rd_cnt = 0, wr_cnt = 0;
  bit finished = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // card model: next byte is always offered; it advances when taken
  always @(posedge clk or negedge rst_n)
    if (!rst_n) card_rdata_i <= 8'h10;
    else if (card_rd_o) card_rdata_i <= card_rdata_i + 8'd7;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (card_rd_o) begin rxq.push_back(card_rdata_i); rd_cnt++; end
      if (card_wr_o) begin
        wr_cnt++;
        if (txq.size() == 0) chk(1'b0, "R3 byte sent with nothing expected", card_wdata_o, 0);
        else begin
          logic [7:0] e;
          e = txq.pop_front();
          chk(card_wdata_o == e, "R3 card byte order", card_wdata_o, e);
        end
      end
      if (card_rd_o && card_wr_o) chk(1'b0, "R11 both card strobes high", 1, 0);
    end
  end

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic bus_read(input logic [1:0] sz);
    int n, eff;
    logic [31:0] e;
    @(negedge clk); rx_rd_i = 1; rx_size_i = sz; #1;
    n = nb(sz);
    eff = (int'(rx_level_o) < n) ? int'(rx_level_o) : n;
    e = '0;
    for (int i = 0; i < eff; i++) e[(n-1-i)*8 +: 8] = rxq.pop_front();
    chk(rx_rdata_o == e, "R4 packed read data", rx_rdata_o, e);
    @(negedge clk); rx_rd_i = 0; #1;
    chk(!rx_req_o, "R6 request low after read", rx_req_o, 0);
  endtask

  task automatic bus_write(input logic [1:0] sz, input logic [31:0] d);
    int n, room;
    @(negedge clk); tx_wr_i = 1; tx_size_i = sz; tx_wdata_i = d; #1;
    n = nb(sz);
    room = DEPTH - int'(tx_level_o);
    for (int i = 0; i < n && i < room; i++) txq.push_back(d[(n-1-i)*8 +: 8]);
    @(negedge clk); tx_wr_i = 0; #1;
    chk(!tx_req_o, "R7 request low after write", tx_req_o, 0);
  endtask

  task automatic start_xfer(input bit wr, input int len, input int cnt);
    @(negedge clk);
    dir_wr_i = wr; blk_len_i = 12'(len); blk_cnt_i = 16'(cnt); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(rx_level_o == 0 && tx_level_o == 0, "R1 stores empty in reset", {rx_level_o, tx_level_o}, 0);
    chk(!rx_req_o && !tx_req_o && !data_done_o && !prog_done_o, "R1 flags low in reset",
        {rx_req_o, tx_req_o, data_done_o, prog_done_o}, 0);
    chk(!card_rd_o && !card_wr_o, "R1 card strobes low in reset", {card_rd_o, card_wr_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // read transfer of 8 x 5 = 40 bytes
    start_xfer(0, 8, 5);
    for (k = 0; k < 100 && rx_level_o != 6'(DEPTH); k++) @(negedge clk);
    @(negedge clk); #1;
    chk(rx_level_o == 6'(DEPTH), "R1 receive store holds 32", rx_level_o, DEPTH);
    chk(!card_rd_o, "R2 no pull while full", card_rd_o, 0);
    chk(rx_req_o, "R6 request when full", rx_req_o, 1);
    chk(!data_done_o, "R8 not done mid transfer", data_done_o, 0);
    for (k = 0; k < 120 && !(data_done_o && rx_level_o == 0); k++) begin
      bus_read((k % 3 == 0) ? 2'd2 : (k % 3 == 1) ? 2'd1 : 2'd0);
    end
    #1;
    chk(data_done_o && !prog_done_o, "R8 read done without programming flag",
        {data_done_o, prog_done_o}, 2'b10);
    chk(rd_cnt == 40, "R10 total equals length times count", rd_cnt, 40);
    chk(rxq.size() == 0, "R2 every card byte delivered", rxq.size(), 0);
    bus_read(2'd3);

    // write transfer of 4 x 3 = 12 bytes
    start_xfer(1, 4, 3);
    repeat (2) @(negedge clk); #1;
    chk(tx_req_o, "R7 request when store empty", tx_req_o, 1);
    bus_write(2'd2, 32'hA1A2A3A4);
    repeat (4) @(negedge clk); #1;
    chk(tx_level_o == 4 && wr_cnt == 0, "R3 held below remaining count", tx_level_o, 4);
    bus_write(2'd2, 32'hB1B2B3B4);
    bus_write(2'd2, 32'hC1C2C3C4);
    for (k = 0; k < 40 && !data_done_o; k++) @(negedge clk);
    #1;
    chk(data_done_o && prog_done_o, "R8 write done with programming flag",
        {data_done_o, prog_done_o}, 2'b11);
    chk(wr_cnt == 12 && txq.size() == 0, "R3 all bytes sent", wr_cnt, 12);

    // partial buffer flush
    start_xfer(1, 64, 1);
    bus_write(2'd1, 32'h00005152);
    bus_write(2'd0, 32'h00000053);
    repeat (4) @(negedge clk); #1;
    chk(tx_level_o == 3 && wr_cnt == 12, "R9 partial store held before flush", tx_level_o, 3);
    @(negedge clk); flush_i = 1;
    @(negedge clk); flush_i = 0;
    for (k = 0; k < 20 && tx_level_o != 0; k++) @(negedge clk);
    repeat (2) @(negedge clk); #1;
    chk(tx_level_o == 0 && wr_cnt == 15, "R9 flush drained store", wr_cnt, 15);
    chk(tx_req_o && !data_done_o, "R7 request after flush drain", {tx_req_o, data_done_o}, 2'b10);

    // zero-length transfer
    start_xfer(1, 0, 5);
    @(negedge clk); #1;
    chk(data_done_o && prog_done_o, "R10 zero total completes at once",
        {data_done_o, prog_done_o}, 2'b11);

    // overflow while idle, then send the full store
    for (int w = 0; w < 9; w++) bus_write(2'd2, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
    #1;
    chk(tx_level_o == 6'(DEPTH) && wr_cnt == 15, "R5 store caps at 32", tx_level_o, DEPTH);
    start_xfer(1, 32, 1);
    for (k = 0; k < 60 && !data_done_o; k++) @(negedge clk);
    #1;
    chk(wr_cnt == 47 && txq.size() == 0, "R5 excess bytes discarded", wr_cnt, 47);
    chk(tx_level_o == 0 && prog_done_o, "R11 full store sent one byte per cycle", tx_level_o, 0);

    finish_run();
  end
endmodule